// File: doc/BRIEF.md
# Egress Switch Tag Splicer

This block sits on the transmit path from a host processor to an Ethernet switch. Frames arrive one byte per cycle on a valid/ready stream, with no tag. A small port number comes with each frame as sideband. The block forwards the two MAC address fields unchanged. It then inserts a 16-bit switch tag that names the egress port, and after the tag it forwards the rest of the frame. Checksums, VLAN tags and padding are not touched.

The tag is built from the port number sampled with the first byte of the frame. It is sent with the high byte first. Bits 15:14 hold version value 2. Bits 13:8 are zero. Bit 7 marks the frame as coming from the host, and bits 6:0 hold a one-hot bitmap of the target port.

While the two tag bytes leave, the input is held off. Backpressure from the output is honoured in every cycle. The datapath has no storage, so bytes pass through combinationally when not in a tag slot. A frame whose port number is out of range is consumed in full, emits nothing, and raises a one-cycle error pulse.

Top module: `tag_splice_tx`

## Requirements
- R1: After reset, m_valid and drop_err are low while no input is offered.
- R2: The first 12 bytes of a frame of 12 or more bytes appear on the output unchanged and in order, with m_last low.
- R3: Output byte 12 (counting from 0) is the tag high byte 8'h80: version 2 in tag bits 15:14, and priority and control fields zero.
- R4: Output byte 13 is the tag low byte. Bit 7 is 1, and bits 6:0 are one-hot, with only bit p set for port p.
- R5: The input bytes from index 12 onward follow the tag unchanged. The output frame is exactly 2 bytes longer than the input, and m_last is set only on its final byte.
- R6: When the input frame is exactly 12 bytes long, m_last moves from the 12th byte to the tag low byte.
- R7: s_ready is low in both cycles in which a tag byte is offered on the output.
- R8: While m_valid is high and m_ready is low, m_valid stays high and m_data and m_last hold their values.
- R9: A frame whose first-byte port number is 7 or above is consumed whole, and no byte of it is emitted. drop_err pulses high for exactly one cycle, in the cycle after that first byte is accepted.
- R10: A frame shorter than 12 bytes passes through unchanged, with no tag and with m_last on its own final byte.
- R11: The port number is sampled only with the first byte. Its value during later bytes of the frame has no effect on the tag or on dropping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted when high with s_valid |
| s_data | input | 8 | Input frame byte |
| s_last | input | 1 | Final byte of input frame |
| s_port | input | PORT_W (3) | Egress port number, sampled with the first byte |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream can take a byte |
| m_data | output | 8 | Output frame byte |
| m_last | output | 1 | Final byte of output frame |
| drop_err | output | 1 | One-cycle pulse when a frame is dropped for a bad port |

## Verification
The bench uses the default parameters: a 3-bit port field, seven ports and a 12-byte address prefix. With these values, port code 7 is the only out-of-range number, and random port draws hit it about one frame in eight. Random frame lengths of 1 to 60 bytes cover short frames, frames of exactly 12 bytes and long bodies. Random output stalls, input gaps and port values that change during a frame then exercise the tag slots, the movement of m_last and the hold behaviour under backpressure.

// File: rtl/tagins_pkg.sv
package tagins_pkg;
  localparam int BYTE_W = 8;
  localparam int MAP_W  = 7;

  typedef enum logic [2:0] {
    ST_ADDR   = 3'd0,
    ST_HDR_HI = 3'd1,
    ST_HDR_LO = 3'd2,
    ST_BODY   = 3'd3,
    ST_DROP   = 3'd4
  } tag_state_e;
endpackage

// File: rtl/tagins_hdr.sv
module tagins_hdr #(
  parameter int PORT_W      = 3,
  parameter int NUM_PORTS   = 7,
  parameter int HDR_VERSION = 2
) (
  input  logic [PORT_W-1:0]              port_q,
  output logic [tagins_pkg::BYTE_W-1:0]  hdr_hi,
  output logic [tagins_pkg::BYTE_W-1:0]  hdr_lo
);
  import tagins_pkg::*;

  logic [MAP_W-1:0] port_map;

  for (genvar g = 0; g < MAP_W; g++) begin : g_map
    if (g < NUM_PORTS) begin : g_live
      assign port_map[g] = (port_q == PORT_W'(g));
    end else begin : g_dead
      assign port_map[g] = 1'b0;
    end
  end

  // version in the top two bits, priority and control fields zero
  assign hdr_hi = {2'(HDR_VERSION), 6'b000000};
  // host-origin flag above the egress bitmap
  assign hdr_lo = {1'b1, port_map};
endmodule

// File: rtl/tagins_ctrl.sv
module tagins_ctrl #(
  parameter int PORT_W     = 3,
  parameter int NUM_PORTS  = 7,
  parameter int ADDR_BYTES = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_last,
  input  logic [PORT_W-1:0]        in_port,
  input  logic                     in_fire,
  input  logic                     out_fire,
  output tagins_pkg::tag_state_e   state,
  output logic                     at_addr_end,
  output logic                     bad_first,
  output logic                     tail_q,
  output logic [PORT_W-1:0]        port_q,
  output logic                     drop_err
);
  import tagins_pkg::*;

  localparam int CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0]  LAST_ADDR = CNT_W'(ADDR_BYTES - 1);
  localparam logic [PORT_W:0]   PORT_LIM  = (PORT_W+1)'(NUM_PORTS);

  tag_state_e       state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tail_d, tail_en;
  logic             port_en;
  logic             err_d;
  logic             at_first;

  assign at_first    = (state == ST_ADDR) && (cnt_q == '0);
  assign at_addr_end = (state == ST_ADDR) && (cnt_q == LAST_ADDR);
  assign bad_first   = at_first && ({1'b0, in_port} >= PORT_LIM);

  always_comb begin
    state_d = state;
    cnt_d   = cnt_q;
    tail_d  = tail_q;
    tail_en = 1'b0;
    port_en = 1'b0;
    err_d   = 1'b0;
    case (state)
      ST_ADDR: begin
        if (in_fire) begin
          if (bad_first) begin
            err_d = 1'b1;
            if (!in_last) state_d = ST_DROP;
          end else begin
            if (at_first) port_en = 1'b1;
            if (cnt_q == LAST_ADDR) begin
              state_d = ST_HDR_HI;
              cnt_d   = '0;
              tail_d  = in_last;
              tail_en = 1'b1;
            end else if (in_last) begin
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
      end
      ST_HDR_HI: begin
        if (out_fire) state_d = ST_HDR_LO;
      end
      ST_HDR_LO: begin
        if (out_fire) state_d = tail_q ? ST_ADDR : ST_BODY;
      end
      ST_BODY: begin
        if (in_fire && in_last) state_d = ST_ADDR;
      end
      ST_DROP: begin
        if (in_fire && in_last) state_d = ST_ADDR;
      end
      default: state_d = ST_ADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_ADDR;
      cnt_q    <= '0;
      drop_err <= 1'b0;
    end else begin
      state    <= state_d;
      cnt_q    <= cnt_d;
      drop_err <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= 1'b0;
    end else if (tail_en) begin
      tail_q <= tail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
    end else if (port_en) begin
      port_q <= in_port;
    end
  end
endmodule

// File: rtl/tagins_path.sv
module tagins_path (
  input  tagins_pkg::tag_state_e          state,
  input  logic                            bad_first,
  input  logic                            at_addr_end,
  input  logic                            tail_q,
  input  logic [tagins_pkg::BYTE_W-1:0]   hdr_hi,
  input  logic [tagins_pkg::BYTE_W-1:0]   hdr_lo,
  input  logic                            s_valid,
  input  logic [tagins_pkg::BYTE_W-1:0]   s_data,
  input  logic                            s_last,
  input  logic                            m_ready,
  output logic                            s_ready,
  output logic                            m_valid,
  output logic [tagins_pkg::BYTE_W-1:0]   m_data,
  output logic                            m_last,
  output logic                            in_fire,
  output logic                            out_fire
);
  import tagins_pkg::*;

  always_comb begin
    s_ready = 1'b0;
    m_valid = 1'b0;
    m_data  = s_data;
    m_last  = 1'b0;
    case (state)
      ST_ADDR: begin
        m_valid = s_valid && !bad_first;
        m_last  = s_last && !at_addr_end;
        s_ready = bad_first ? 1'b1 : m_ready;
      end
      ST_HDR_HI: begin
        m_valid = 1'b1;
        m_data  = hdr_hi;
      end
      ST_HDR_LO: begin
        m_valid = 1'b1;
        m_data  = hdr_lo;
        m_last  = tail_q;
      end
      ST_BODY: begin
        m_valid = s_valid;
        m_last  = s_last;
        s_ready = m_ready;
      end
      ST_DROP: begin
        s_ready = 1'b1;
      end
      default: begin
        s_ready = 1'b0;
      end
    endcase
  end

  assign in_fire  = s_valid && s_ready;
  assign out_fire = m_valid && m_ready;
endmodule

// File: rtl/tag_splice_tx.sv
module tag_splice_tx #(
  parameter int PORT_W      = 3,
  parameter int NUM_PORTS   = 7,
  parameter int ADDR_BYTES  = 12,
  parameter int HDR_VERSION = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [7:0]         s_data,
  input  logic               s_last,
  input  logic [PORT_W-1:0]  s_port,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [7:0]         m_data,
  output logic               m_last,
  output logic               drop_err
);
  import tagins_pkg::*;

  tag_state_e        state;
  logic              at_addr_end;
  logic              bad_first;
  logic              tail_q;
  logic [PORT_W-1:0] port_q;
  logic              in_fire;
  logic              out_fire;
  logic [BYTE_W-1:0] hdr_hi;
  logic [BYTE_W-1:0] hdr_lo;

  tagins_ctrl #(
    .PORT_W     (PORT_W),
    .NUM_PORTS  (NUM_PORTS),
    .ADDR_BYTES (ADDR_BYTES)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_last     (s_last),
    .in_port     (s_port),
    .in_fire     (in_fire),
    .out_fire    (out_fire),
    .state       (state),
    .at_addr_end (at_addr_end),
    .bad_first   (bad_first),
    .tail_q      (tail_q),
    .port_q      (port_q),
    .drop_err    (drop_err)
  );

  tagins_hdr #(
    .PORT_W      (PORT_W),
    .NUM_PORTS   (NUM_PORTS),
    .HDR_VERSION (HDR_VERSION)
  ) u_hdr (
    .port_q (port_q),
    .hdr_hi (hdr_hi),
    .hdr_lo (hdr_lo)
  );

  tagins_path u_path (
    .state       (state),
    .bad_first   (bad_first),
    .at_addr_end (at_addr_end),
    .tail_q      (tail_q),
    .hdr_hi      (hdr_hi),
    .hdr_lo      (hdr_lo),
    .s_valid     (s_valid),
    .s_data      (s_data),
    .s_last      (s_last),
    .m_ready     (m_ready),
    .s_ready     (s_ready),
    .m_valid     (m_valid),
    .m_data      (m_data),
    .m_last      (m_last),
    .in_fire     (in_fire),
    .out_fire    (out_fire)
  );
endmodule

// File: rtl/tagins_chk.sv
module tagins_chk #(
  parameter int ADDR_BYTES  = 12,
  parameter int HDR_VERSION = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       s_valid,
  input logic       s_ready,
  input logic       m_valid,
  input logic       m_ready,
  input logic [7:0] m_data,
  input logic       m_last,
  input logic       drop_err
);
  localparam logic [15:0] HI_IDX = 16'(ADDR_BYTES);
  localparam logic [15:0] LO_IDX = 16'(ADDR_BYTES + 1);

  logic [15:0] oidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oidx <= '0;
    end else if (m_valid && m_ready) begin
      if (m_last)              oidx <= '0;
      else if (oidx != 16'hFFFF) oidx <= oidx + 16'd1;
    end
  end

  assert_tag_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && oidx == HI_IDX) |-> (m_data == {2'(HDR_VERSION), 6'b000000}));

  assert_tag_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && oidx == LO_IDX) |-> (m_data[7] && $onehot(m_data[6:0])));

  assert_no_last_on_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && oidx == HI_IDX) |-> !m_last);

  assert_stall_in_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && (oidx == HI_IDX || oidx == LO_IDX)) |-> !s_ready);

  assert_hold_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  assert_drop_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |-> $past(s_valid && s_ready && !m_valid));
endmodule

bind tag_splice_tx tagins_chk #(
  .ADDR_BYTES  (ADDR_BYTES),
  .HDR_VERSION (HDR_VERSION)
) u_chk (.*);

// File: tb/tag_splice_tx_test.sv
module tag_splice_tx_test;
  typedef struct {
    logic [7:0] d;
    bit         l;
    string      r;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       s_valid;
  logic       s_ready;
  logic [7:0] s_data;
  logic       s_last;
  logic [2:0] s_port;
  logic       m_valid;
  logic       m_ready;
  logic [7:0] m_data;
  logic       m_last;
  logic       drop_err;

  int   checks = 0;
  int   fails = 0;
  int   err_seen = 0;
  int   err_exp = 0;
  int   oidx = 0;
  bit   ready_rand = 0;
  bit   stall_prev = 0;
  bit   done = 0;
  logic [7:0] prev_d;
  logic       prev_l;
  logic [7:0] frm [64];
  exp_t       expq [$];

  tag_splice_tx uut (
    .clk (clk), .rst_n (rst_n),
    .s_valid (s_valid), .s_ready (s_ready), .s_data (s_data),
    .s_last (s_last), .s_port (s_port),
    .m_valid (m_valid), .m_ready (m_ready), .m_data (m_data),
    .m_last (m_last), .drop_err (drop_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic void push(input logic [7:0] d, input bit l, input string r);
    exp_t e;
    e.d = d; e.l = l; e.r = r;
    expq.push_back(e);
  endfunction

  // expected output of one frame, built from the requirements
  function automatic void expect_frame(input int len, input int port);
    if (port >= 7) begin
      err_exp++;
      return;
    end
    if (len < 12) begin
      for (int i = 0; i < len; i++) push(frm[i], i == len - 1, "R10");
      return;
    end
    for (int i = 0; i < 12; i++) push(frm[i], 1'b0, "R2");
    push(8'h80, 1'b0, "R3");
    push(8'h80 | (8'h01 << port), len == 12, "R4/R6/R11");
    for (int i = 12; i < len; i++) push(frm[i], i == len - 1, "R5");
  endfunction

  task automatic send_frame(input int len, input int port, input bit gaps);
    for (int i = 0; i < len; i++) frm[i] = 8'($urandom);
    expect_frame(len, port);
    for (int i = 0; i < len; i++) begin
      if (gaps && ($urandom % 3 == 0)) begin
        s_valid = 1'b0;
        @(posedge clk); #1;
      end
      s_valid = 1'b1;
      s_data  = frm[i];
      s_last  = (i == len - 1);
      // R11: later bytes carry arbitrary port values
      s_port  = (i == 0) ? 3'(port) : 3'($urandom % 8);
      do @(negedge clk); while (!s_ready);
      @(posedge clk); #1;
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  always @(posedge clk) begin
    #1;
    m_ready = ready_rand ? ($urandom % 4 != 0) : 1'b1;
  end

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)
        chk(m_valid && m_data == prev_d && m_last == prev_l, "R8 hold", int'(m_data), int'(prev_d));
      stall_prev = m_valid && !m_ready;
      prev_d = m_data;
      prev_l = m_last;
      if (m_valid && (oidx == 12 || oidx == 13))
        chk(!s_ready, "R7 ready during tag", int'(s_ready), 0);
      if (drop_err) err_seen++;
      if (m_valid && m_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R9 unexpected byte", int'(m_data), -1);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(m_data == e.d, e.r, int'(m_data), int'(e.d));
          chk(m_last == e.l, {e.r, " last"}, int'(m_last), int'(e.l));
        end
        oidx = m_last ? 0 : oidx + 1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R5 watchdog pending bytes", expq.size(), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n   = 1'b0;
    s_valid = 1'b0;
    s_data  = '0;
    s_last  = 1'b0;
    s_port  = '0;
    m_ready = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(m_valid == 1'b0, "R1 m_valid after reset", int'(m_valid), 0);
    chk(drop_err == 1'b0, "R1 drop_err after reset", int'(drop_err), 0);
    @(posedge clk); #1;

    // directed corners
    send_frame(12, 3, 0);   // R6
    send_frame(11, 2, 0);   // R10
    send_frame(1, 5, 0);    // R10
    send_frame(13, 0, 0);   // R4
    send_frame(1, 7, 0);    // R9 single-byte drop
    send_frame(20, 7, 0);   // R9
    send_frame(30, 6, 0);   // R5
    ready_rand = 1;
    send_frame(12, 1, 1);   // R6 under stalls
    send_frame(25, 7, 1);   // R9 under stalls
    send_frame(40, 4, 1);   // R8

    for (int f = 0; f < 60; f++)
      send_frame(1 + int'($urandom % 60), int'($urandom % 8), 1'($urandom % 2));

    ready_rand = 0;
    for (int w = 0; w < 500 && expq.size() != 0; w++) @(posedge clk);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(expq.size() == 0, "R5 all bytes delivered", expq.size(), 0);
    chk(err_seen == err_exp, "R9 drop pulses", err_seen, err_exp);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule